// File: doc/BRIEF.md
# Lane Vector Register File with Length-Dependent Addressing

This block is the register storage that sits inside one lane of a multi-lane vector unit. It holds 256 words of 32 bits. Three read ports and two write ports reach it at once. Read ports 0 and 1 feed the two ALU operands, and read port 2 feeds the store path. Write port 0 takes ALU results and write port 1 takes load results. Every port names a vector register and an element index rather than a raw address. The block maps that pair onto a physical word using a run-time vector-length code. The same 256 words therefore appear as 64 short, 32 medium or 16 long registers, and a long register overlays two medium ones.

Reads are registered. An enabled read port shows its word one clock after the request, and a disabled port keeps the last value it returned. A read that meets a write to the same word in the same cycle returns the value being written. When both write ports hit one word, the load port wins and a collision flag pulses. Any access that falls outside the register file for the current length is dropped, and an error flag pulses.

The ports are plain enable-qualified memory ports. There is no valid/ready handshake and no back-pressure. Every enabled request is accepted in the cycle it is presented, and read data comes back with a fixed latency of one cycle. The requester therefore never waits and never has to hold a request.

Top module: `lane_vrf`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every `rd_data` lane is zero and `wr_collide` and `addr_err` are low.
- R2: `vl_mode` selects the per-lane register span. Code 0 gives 4 elements per register (64 registers), code 1 gives 8 (32 registers) and code 2 gives 16 (16 registers). The word address is register × span + element, so one word is reachable under every valid code.
- R3: An enabled read port shows the addressed word on the clock edge that samples its request. The value is visible from that edge until the next edge.
- R4: A read port whose enable is low keeps its previous output, even when the word it last read is overwritten.
- R5: A read of a word that is being written in the same cycle returns the new data. If both write ports target that word, the read returns the load-port data.
- R6: Two enabled write ports that target different words in one cycle both store their data, and `wr_collide` stays low.
- R7: When both write ports target the same word in one cycle, the load port (port 1) data is stored and `wr_collide` is high for exactly the next cycle.
- R8: An access is out of range when `vl_mode` is 3, when the register number is at or above 64 >> `vl_mode`, or when the element is at or above 4 << `vl_mode`. An out-of-range access raises `addr_err` for the next cycle. An out-of-range write changes no word, and an out-of-range read leaves its port output unchanged.
- R9: All three read ports work independently in the same cycle, each returning its own addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vl_mode | input | 2 | Vector-length code: 0 = 16, 1 = 32, 2 = 64, 3 = invalid |
| rd_en | input | 3 | Per-port read enable (0, 1 = ALU operands, 2 = store) |
| rd_reg | input | 3×6 | Per-port register number |
| rd_elem | input | 3×4 | Per-port element index within the lane |
| rd_data | output | 3×32 | Per-port registered read data |
| wr_en | input | 2 | Per-port write enable (0 = ALU write-back, 1 = load write-back) |
| wr_reg | input | 2×6 | Per-port register number |
| wr_elem | input | 2×4 | Per-port element index within the lane |
| wr_data | input | 2×32 | Per-port write data |
| wr_collide | output | 1 | Pulse: both write ports hit one word in the previous cycle |
| addr_err | output | 1 | Pulse: an out-of-range access was dropped in the previous cycle |

## Verification
The bench builds the block with its default parameters: 256 words, a smallest span of four elements, and three valid length codes. With these values every length code can be exercised, and the top word (address 255) is reachable from all three register views. A table of writes under one length code and reads under another shows that short, medium and long registers overlay as the address formula predicts. Directed cases then cover same-cycle forwarding, both write-collision outcomes, enable-low holding, and the three ways an access can fall out of range. Each out-of-range case is checked by reading back the word the dropped access would have reached.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int DEF_DATA_W    = 32;
  localparam int DEF_DEPTH     = 256;
  localparam int DEF_MIN_SHIFT = 2;
  localparam int DEF_NUM_MODES = 3;
  localparam int DEF_NRD       = 3;
  localparam int DEF_NWR       = 2;

  // write port roles; a higher index takes precedence on a shared word
  localparam int WR_ALU  = 0;
  localparam int WR_LOAD = 1;

  typedef enum logic [1:0] {
    VL_SHORT = 2'd0,
    VL_MID   = 2'd1,
    VL_LONG  = 2'd2,
    VL_BAD   = 2'd3
  } vl_code_e;
endpackage

// File: rtl/lrf_addr_map.sv
module lrf_addr_map #(
  parameter int ADDR_W    = 8,
  parameter int REG_W     = 6,
  parameter int ELEM_W    = 4,
  parameter int MODE_W    = 2,
  parameter int MIN_SHIFT = 2,
  parameter int NUM_MODES = 3
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [REG_W-1:0]  reg_id,
  input  logic [ELEM_W-1:0] elem,
  output logic [ADDR_W-1:0] addr,
  output logic              ok
);
  localparam int WIDE = ADDR_W + ELEM_W + 2;
  localparam logic [WIDE-1:0] DEPTH_W = WIDE'(1) << ADDR_W;

  logic [WIDE-1:0] span;
  logic [WIDE-1:0] full;
  logic            mode_ok;
  int unsigned     sh;

  always_comb begin
    sh      = MIN_SHIFT + 32'(mode);
    span    = WIDE'(1) << sh;
    full    = (WIDE'(reg_id) << sh) + WIDE'(elem);
    mode_ok = (32'(mode) < NUM_MODES);
    ok      = mode_ok && (WIDE'(elem) < span) && (full < DEPTH_W);
    addr    = full[ADDR_W-1:0];
  end
endmodule

// File: rtl/lrf_wr_arb.sv
module lrf_wr_arb #(
  parameter int NWR    = 2,
  parameter int ADDR_W = 8
) (
  input  logic [NWR-1:0]             req,
  input  logic [NWR-1:0][ADDR_W-1:0] addr,
  output logic [NWR-1:0]             wen,
  output logic                       collide
);
  always_comb begin
    collide = 1'b0;
    for (int i = 0; i < NWR; i++) begin
      wen[i] = req[i];
      for (int j = i + 1; j < NWR; j++) begin
        if (req[i] && req[j] && addr[i] == addr[j]) begin
          wen[i]  = 1'b0;
          collide = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lrf_bank.sv
module lrf_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 256,
  parameter int NRD    = 3,
  parameter int NWR    = 2,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NWR-1:0]             wen,
  input  logic [NWR-1:0][ADDR_W-1:0] waddr,
  input  logic [NWR-1:0][DATA_W-1:0] wdata,
  input  logic [NRD-1:0]             ren,
  input  logic [NRD-1:0][ADDR_W-1:0] raddr,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // the arbiter guarantees that enabled write addresses are distinct
  always_ff @(posedge clk) begin
    for (int w = 0; w < NWR; w++) begin
      if (wen[w]) mem[waddr[w]] <= wdata[w];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [DATA_W-1:0] next_val;

    // write-first: a same-cycle write is forwarded, highest port last
    always_comb begin
      next_val = mem[raddr[p]];
      for (int w = 0; w < NWR; w++) begin
        if (wen[w] && waddr[w] == raddr[p]) next_val = wdata[w];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)      rdata[p] <= '0;
      else if (ren[p]) rdata[p] <= next_val;
    end
  end
endmodule

// File: rtl/lane_vrf.sv
module lane_vrf #(
  parameter int DATA_W    = lrf_pkg::DEF_DATA_W,
  parameter int DEPTH     = lrf_pkg::DEF_DEPTH,
  parameter int MIN_SHIFT = lrf_pkg::DEF_MIN_SHIFT,
  parameter int NUM_MODES = lrf_pkg::DEF_NUM_MODES,
  parameter int NRD       = lrf_pkg::DEF_NRD,
  parameter int NWR       = lrf_pkg::DEF_NWR,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int ELEM_W = MIN_SHIFT + NUM_MODES - 1,
  localparam int REG_W  = ADDR_W - MIN_SHIFT,
  localparam int MODE_W = $clog2(NUM_MODES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [MODE_W-1:0]          vl_mode,
  input  logic [NRD-1:0]             rd_en,
  input  logic [NRD-1:0][REG_W-1:0]  rd_reg,
  input  logic [NRD-1:0][ELEM_W-1:0] rd_elem,
  output logic [NRD-1:0][DATA_W-1:0] rd_data,
  input  logic [NWR-1:0]             wr_en,
  input  logic [NWR-1:0][REG_W-1:0]  wr_reg,
  input  logic [NWR-1:0][ELEM_W-1:0] wr_elem,
  input  logic [NWR-1:0][DATA_W-1:0] wr_data,
  output logic                       wr_collide,
  output logic                       addr_err
);
  logic [NRD-1:0][ADDR_W-1:0] rd_addr;
  logic [NRD-1:0]             rd_ok;
  logic [NWR-1:0][ADDR_W-1:0] wr_addr;
  logic [NWR-1:0]             wr_ok;
  logic [NWR-1:0]             wr_req;
  logic [NWR-1:0]             wr_go;
  logic                       collide_now;
  logic                       bad_now;

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    lrf_addr_map #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .ELEM_W(ELEM_W), .MODE_W(MODE_W),
      .MIN_SHIFT(MIN_SHIFT), .NUM_MODES(NUM_MODES)
    ) map_i (
      .mode(vl_mode), .reg_id(rd_reg[p]), .elem(rd_elem[p]),
      .addr(rd_addr[p]), .ok(rd_ok[p])
    );
  end

  for (genvar w = 0; w < NWR; w++) begin : g_wmap
    lrf_addr_map #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .ELEM_W(ELEM_W), .MODE_W(MODE_W),
      .MIN_SHIFT(MIN_SHIFT), .NUM_MODES(NUM_MODES)
    ) map_i (
      .mode(vl_mode), .reg_id(wr_reg[w]), .elem(wr_elem[w]),
      .addr(wr_addr[w]), .ok(wr_ok[w])
    );
  end

  assign wr_req  = wr_en & wr_ok;
  assign bad_now = |(rd_en & ~rd_ok) | |(wr_en & ~wr_ok);

  lrf_wr_arb #(.NWR(NWR), .ADDR_W(ADDR_W)) arb_i (
    .req(wr_req), .addr(wr_addr), .wen(wr_go), .collide(collide_now)
  );

  lrf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NRD(NRD), .NWR(NWR)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .wen(wr_go), .waddr(wr_addr), .wdata(wr_data),
    .ren(rd_en & rd_ok), .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_collide <= 1'b0;
      addr_err   <= 1'b0;
    end else begin
      wr_collide <= collide_now;
      addr_err   <= bad_now;
    end
  end
endmodule

// File: rtl/lane_vrf_chk.sv
module lane_vrf_chk #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 256,
  parameter int MIN_SHIFT = 2,
  parameter int NUM_MODES = 3,
  parameter int NRD       = 3,
  parameter int NWR       = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int ELEM_W = MIN_SHIFT + NUM_MODES - 1,
  localparam int REG_W  = ADDR_W - MIN_SHIFT,
  localparam int MODE_W = $clog2(NUM_MODES + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [MODE_W-1:0]          vl_mode,
  input logic [NRD-1:0]             rd_en,
  input logic [NRD-1:0][REG_W-1:0]  rd_reg,
  input logic [NRD-1:0][ELEM_W-1:0] rd_elem,
  input logic [NRD-1:0][DATA_W-1:0] rd_data,
  input logic [NWR-1:0]             wr_en,
  input logic [NWR-1:0][REG_W-1:0]  wr_reg,
  input logic [NWR-1:0][ELEM_W-1:0] wr_elem,
  input logic [NWR-1:0][DATA_W-1:0] wr_data,
  input logic                       wr_collide,
  input logic                       addr_err
);
  localparam int LONG_REGS = DEPTH >> (MIN_SHIFT + NUM_MODES - 1);

  for (genvar p = 0; p < NRD; p++) begin : g_hold
    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[p] |=> $stable(rd_data[p]));
  end

  // R7
  collide_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_collide |-> $past($countones(wr_en) >= 2));

  // R8
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(vl_mode) >= NUM_MODES) && (|rd_en || |wr_en)) |=> addr_err);

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> $past(|rd_en || |wr_en));

  // R5
  fwd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en[0] && wr_en[NWR-1] && 32'(vl_mode) == NUM_MODES - 1 &&
     32'(rd_reg[0]) < LONG_REGS && rd_reg[0] == wr_reg[NWR-1] &&
     rd_elem[0] == wr_elem[NWR-1])
    |=> rd_data[0] == $past(wr_data[NWR-1]));
endmodule

bind lane_vrf lane_vrf_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .MIN_SHIFT(MIN_SHIFT),
  .NUM_MODES(NUM_MODES), .NRD(NRD), .NWR(NWR)
) chk_i (.*);

// File: tb/lane_vrf_tb_top.sv
module lane_vrf_tb_top;
  logic                clk = 1'b0;
  logic                rst_n;
  logic [1:0]          vl_mode;
  logic [2:0]          rd_en;
  logic [2:0][5:0]     rd_reg;
  logic [2:0][3:0]     rd_elem;
  logic [2:0][31:0]    rd_data;
  logic [1:0]          wr_en;
  logic [1:0][5:0]     wr_reg;
  logic [1:0][3:0]     wr_elem;
  logic [1:0][31:0]    wr_data;
  logic                wr_collide;
  logic                addr_err;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  lane_vrf dut_i (.*);

  // {wmode, wreg, welem, rmode, rreg, relem, data}
  localparam logic [55:0] VEC [8] = '{
    {2'd0, 6'd0,  4'd0,  2'd0, 6'd0,  4'd0,  32'h1111_0000},
    {2'd2, 6'd0,  4'd10, 2'd1, 6'd1,  4'd2,  32'h2222_0001},
    {2'd1, 6'd3,  4'd7,  2'd0, 6'd7,  4'd3,  32'h3333_0002},
    {2'd0, 6'd63, 4'd3,  2'd2, 6'd15, 4'd15, 32'h4444_0003},
    {2'd2, 6'd8,  4'd0,  2'd1, 6'd16, 4'd0,  32'h5555_0004},
    {2'd1, 6'd31, 4'd0,  2'd0, 6'd62, 4'd0,  32'h6666_0005},
    {2'd0, 6'd5,  4'd1,  2'd2, 6'd1,  4'd5,  32'h7777_0006},
    {2'd2, 6'd3,  4'd9,  2'd1, 6'd7,  4'd1,  32'h8888_0007}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    rd_en = '0;
    wr_en = '0;
  endtask

  task automatic set_wr(int p, logic [5:0] r, logic [3:0] e, logic [31:0] d);
    wr_en[p] = 1'b1; wr_reg[p] = r; wr_elem[p] = e; wr_data[p] = d;
  endtask

  task automatic set_rd(int p, logic [5:0] r, logic [3:0] e);
    rd_en[p] = 1'b1; rd_reg[p] = r; rd_elem[p] = e;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vl_mode = 2'd0;
    rd_en = '0; rd_reg = '0; rd_elem = '0;
    wr_en = '0; wr_reg = '0; wr_elem = '0; wr_data = '0;
    repeat (3) tick();
    // R1: state during reset
    for (int p = 0; p < 3; p++) chk("R1 rd_data in reset", rd_data[p], 32'h0);
    chk("R1 wr_collide in reset", {31'b0, wr_collide}, 32'h0);
    chk("R1 addr_err in reset", {31'b0, addr_err}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 rd_data after reset", rd_data[0], 32'h0);

    // R2 / R3: write under one length code, read back under another
    for (int i = 0; i < 8; i++) begin
      idle();
      vl_mode = VEC[i][55:54];
      set_wr(i % 2, VEC[i][53:48], VEC[i][47:44], VEC[i][31:0]);
      tick();
      idle();
      vl_mode = VEC[i][43:42];
      set_rd(i % 3, VEC[i][41:36], VEC[i][35:32]);
      tick();
      chk($sformatf("R2 R3 alias vector %0d", i), rd_data[i % 3], VEC[i][31:0]);
    end

    // R9: three ports in one cycle, long registers
    idle(); vl_mode = 2'd2;
    set_rd(0, 6'd0, 4'd0); set_rd(1, 6'd15, 4'd15); set_rd(2, 6'd3, 4'd9);
    tick();
    chk("R9 port0", rd_data[0], 32'h1111_0000);
    chk("R9 port1", rd_data[1], 32'h4444_0003);
    chk("R9 port2", rd_data[2], 32'h8888_0007);

    // R4: port disabled keeps its output while its word is overwritten
    idle(); set_wr(1, 6'd0, 4'd0, 32'hDEAD_0000);
    tick(); idle(); tick();
    chk("R4 hold on disabled port", rd_data[0], 32'h1111_0000);
    set_rd(0, 6'd0, 4'd0);
    tick();
    chk("R3 read after overwrite", rd_data[0], 32'hDEAD_0000);

    // R5: same-cycle forwarding from the ALU port
    idle(); set_wr(0, 6'd2, 4'd8, 32'hA5A5_0001); set_rd(1, 6'd2, 4'd8);
    tick();
    chk("R5 forward alu write", rd_data[1], 32'hA5A5_0001);

    // R5 / R7: both writes one word, read it in the same cycle
    idle();
    set_wr(0, 6'd2, 4'd9, 32'hC0C0_0000);
    set_wr(1, 6'd2, 4'd9, 32'hD0D0_0000);
    set_rd(2, 6'd2, 4'd9);
    tick();
    chk("R5 forward load wins", rd_data[2], 32'hD0D0_0000);
    chk("R7 collide pulse", {31'b0, wr_collide}, 32'h1);
    idle(); tick();
    chk("R7 collide one cycle", {31'b0, wr_collide}, 32'h0);
    set_rd(0, 6'd2, 4'd9);
    tick();
    chk("R7 stored load data", rd_data[0], 32'hD0D0_0000);

    // R6: both writes to different words
    idle();
    set_wr(0, 6'd2, 4'd10, 32'h0A0A_0A0A);
    set_wr(1, 6'd2, 4'd11, 32'h0B0B_0B0B);
    tick();
    chk("R6 no collide", {31'b0, wr_collide}, 32'h0);
    idle(); set_rd(0, 6'd2, 4'd10); set_rd(1, 6'd2, 4'd11);
    tick();
    chk("R6 alu word stored", rd_data[0], 32'h0A0A_0A0A);
    chk("R6 load word stored", rd_data[1], 32'h0B0B_0B0B);

    // R8: register beyond range for long registers
    idle(); set_wr(1, 6'd0, 4'd0, 32'h5A5A_0000);
    tick();
    idle(); set_wr(1, 6'd16, 4'd0, 32'hFFFF_FFFF);
    tick();
    chk("R8 err on reg range", {31'b0, addr_err}, 32'h1);
    idle(); tick();
    chk("R8 err clears", {31'b0, addr_err}, 32'h0);
    set_rd(0, 6'd0, 4'd0);
    tick();
    chk("R8 reg range write dropped", rd_data[0], 32'h5A5A_0000);

    // R8: element beyond range for short registers
    idle(); vl_mode = 2'd0; set_wr(0, 6'd1, 4'd0, 32'h0000_0044);
    tick();
    idle(); set_wr(0, 6'd0, 4'd4, 32'h0000_0099);
    tick();
    chk("R8 err on elem range", {31'b0, addr_err}, 32'h1);
    idle(); set_rd(1, 6'd1, 4'd0);
    tick();
    chk("R8 elem range write dropped", rd_data[1], 32'h0000_0044);

    // R8: invalid length code
    idle(); vl_mode = 2'd3; set_wr(1, 6'd0, 4'd0, 32'h0000_0077);
    tick();
    chk("R8 err on mode 3", {31'b0, addr_err}, 32'h1);
    idle(); vl_mode = 2'd2; set_rd(2, 6'd0, 4'd0);
    tick();
    chk("R8 mode 3 write dropped", rd_data[2], 32'h5A5A_0000);

    // R8: out-of-range read leaves the port output alone
    idle(); set_rd(1, 6'd20, 4'd0);
    tick();
    chk("R8 err on bad read", {31'b0, addr_err}, 32'h1);
    chk("R8 bad read holds output", rd_data[1], 32'h0000_0044);

    idle(); tick();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule